// File: doc/BRIEF.md
# Instruction Address Breakpoint Comparator

This debug unit sits beside the fetch and issue logic of a 64-bit processor core. It holds a single 64-bit breakpoint register. Software loads the register through a special-register write port and can read it back unchanged. A second load path, used when saved processor state is brought back, puts a snapshot value into the same register. The breakpoint is then re-armed from that value in the same way as after an ordinary write.

In every cycle the unit compares the address of the next instruction against the stored word-aligned address. It also checks whether the current privilege state, given by the problem-state bit and the hypervisor bit, matches the two-bit privilege selector held in the low bits of the register. When an instruction is presented as valid and both checks pass, the unit raises a one-cycle trace-class debug exception request in the following cycle. The request carries a fixed status word. Delivering the exception is the job of the surrounding core.

Top module: `ibrk_unit`

## Requirements
- R1: After reset, and after any later reset, `bp_rdata` is zero, `trace_req` is low, `trace_status` is zero, and any armed breakpoint is removed.
- R2: A write through `bp_we`/`bp_wdata` is returned unchanged on `bp_rdata` from the next cycle on.
- R3: Privilege selector 0 (bits [1:0] of the register, conventional numbering) disables the breakpoint, so no request is ever raised.
- R4: Selector 1 matches only when `st_pr` is 1, whatever the value of `st_hv`.
- R5: Selector 2 matches only when `st_pr` is 0 and `st_hv` is 0.
- R6: Selector 3 matches only when `st_pr` is 0 and `st_hv` is 1.
- R7: An address hit requires `nia` to equal register bits [63:2] followed by two zero bits. Any other `nia` value gives no request, including a value that differs only in bits [1:0].
- R8: `trace_req` is high for exactly the one cycle after a cycle in which `nia_valid` was high and the address and privilege both matched. When `nia_valid` is low, no request follows.
- R9: While `trace_req` is high, `trace_status` equals 64'h0000_0000_4010_0000 (bits 30 and 20 set). At all other times it is zero.
- R10: A new register value governs matching from the cycle after the write. The comparison made in the same cycle as the write still uses the old value, so the previous breakpoint is dropped cleanly.
- R11: `rs_en`/`rs_data` loads the register and re-arms the breakpoint from the loaded value. When both load paths are active in the same cycle, the restore path wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bp_we | input | 1 | Software write strobe for the breakpoint register |
| bp_wdata | input | 64 | Software write data |
| rs_en | input | 1 | State-restore load strobe |
| rs_data | input | 64 | State-restore value |
| bp_rdata | output | 64 | Current breakpoint register value |
| nia_valid | input | 1 | Next instruction address is valid this cycle |
| nia | input | 64 | Next instruction address |
| st_pr | input | 1 | Machine state: problem (user) state bit |
| st_hv | input | 1 | Machine state: hypervisor bit |
| trace_req | output | 1 | One-cycle trace exception request |
| trace_status | output | 64 | Status word accompanying the request |

## Verification
A register load and an address comparison can fall in the same cycle, as can the two load paths. The bench provokes the first case by writing a new breakpoint while `nia` already equals the new address in the qualifying state. It judges the result against its own model: no request may come from that cycle, and one must come on the next matching cycle. The second case drives a write and a restore together, each with a different address. It then checks that the read-back value and the subsequent hits both follow the restore value.

// File: rtl/ibrk_pkg.sv
package ibrk_pkg;

  localparam int PRIV_W = 2;

  typedef enum logic [PRIV_W-1:0] {
    SEL_OFF  = 2'd0,
    SEL_USER = 2'd1,
    SEL_SUP  = 2'd2,
    SEL_HYP  = 2'd3
  } priv_sel_e;

  // True when the machine state satisfies the given selector.
  function automatic logic priv_qualifies(input priv_sel_e sel, input logic pr, input logic hv);
    logic ok;
    case (sel)
      SEL_USER: ok = pr;
      SEL_SUP:  ok = !pr && !hv;
      SEL_HYP:  ok = !pr && hv;
      default:  ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/ibrk_reg.sv
module ibrk_reg #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wr_data,
  input  logic            ld_en,
  input  logic [XLEN-1:0] ld_data,
  output logic [XLEN-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)      q <= '0;
    else if (ld_en)  q <= ld_data;   // restore has priority
    else if (wr_en)  q <= wr_data;
  end

  a_r2_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && !$past(ld_en)) |-> (q == $past(wr_data)));

  a_r11_restore_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ld_en)) |-> (q == $past(ld_data)));

  a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_en) && !$past(ld_en)) |-> $stable(q));

endmodule

// File: rtl/ibrk_match.sv
module ibrk_match
  import ibrk_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] bp,
  input  logic [XLEN-1:0] nia,
  input  logic            pr,
  input  logic            hv,
  output logic            addr_hit,
  output logic            priv_hit,
  output logic            armed
);

  localparam int NSEL = 2 ** PRIV_W;

  priv_sel_e       sel;
  logic [NSEL-1:0] mode_ok;

  assign sel      = priv_sel_e'(bp[PRIV_W-1:0]);
  assign armed    = (sel != SEL_OFF);
  assign addr_hit = (nia == {bp[XLEN-1:PRIV_W], {PRIV_W{1'b0}}});

  // One decode lane per selector value; lane 0 is the disabled setting.
  assign mode_ok[0] = 1'b0;
  for (genvar m = 1; m < NSEL; m++) begin : g_mode
    assign mode_ok[m] = (sel == priv_sel_e'(m)) && priv_qualifies(priv_sel_e'(m), pr, hv);
  end

  assign priv_hit = |mode_ok;

  always_comb begin
    a_r3_off_no_priv: assert (armed || !priv_hit);
    a_r4_onehot_mode: assert ($onehot0(mode_ok));
  end

endmodule

// File: rtl/ibrk_req.sv
module ibrk_req #(
  parameter int XLEN  = 64,
  parameter int STS_A = 33,
  parameter int STS_B = 43
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  output logic            req,
  output logic [XLEN-1:0] status
);

  // Status bits are given in most-significant-first numbering.
  localparam logic [XLEN-1:0] STS_WORD =
    (XLEN'(1) << (XLEN - 1 - STS_A)) | (XLEN'(1) << (XLEN - 1 - STS_B));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req    <= 1'b0;
      status <= '0;
    end else begin
      req    <= fire;
      status <= fire ? STS_WORD : '0;
    end
  end

  a_r9_status_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (status == STS_WORD));

  a_r9_status_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> (status == '0));

endmodule

// File: rtl/ibrk_unit.sv
module ibrk_unit
  import ibrk_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int STS_A = 33,
  parameter int STS_B = 43
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bp_we,
  input  logic [XLEN-1:0] bp_wdata,
  input  logic            rs_en,
  input  logic [XLEN-1:0] rs_data,
  output logic [XLEN-1:0] bp_rdata,
  input  logic            nia_valid,
  input  logic [XLEN-1:0] nia,
  input  logic            st_pr,
  input  logic            st_hv,
  output logic            trace_req,
  output logic [XLEN-1:0] trace_status
);

  logic [XLEN-1:0] bp_q;
  logic            addr_hit;
  logic            priv_hit;
  logic            armed;
  logic            fire;

  ibrk_reg #(.XLEN(XLEN)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bp_we),
    .wr_data (bp_wdata),
    .ld_en   (rs_en),
    .ld_data (rs_data),
    .q       (bp_q)
  );

  ibrk_match #(.XLEN(XLEN)) u_match (
    .bp       (bp_q),
    .nia      (nia),
    .pr       (st_pr),
    .hv       (st_hv),
    .addr_hit (addr_hit),
    .priv_hit (priv_hit),
    .armed    (armed)
  );

  assign fire = nia_valid && armed && priv_hit && addr_hit;

  ibrk_req #(.XLEN(XLEN), .STS_A(STS_A), .STS_B(STS_B)) u_req (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (fire),
    .req    (trace_req),
    .status (trace_status)
  );

  assign bp_rdata = bp_q;

  a_r8_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    trace_req |-> $past(nia_valid));

  a_r3_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bp_q[PRIV_W-1:0]) == SEL_OFF) |-> !trace_req);

  a_r4_user_state: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_req && $past(bp_q[PRIV_W-1:0]) == SEL_USER) |-> $past(st_pr));

  a_r5_super_state: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_req && $past(bp_q[PRIV_W-1:0]) == SEL_SUP) |-> ($past(!st_pr) && $past(!st_hv)));

  a_r6_hyp_state: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_req && $past(bp_q[PRIV_W-1:0]) == SEL_HYP) |-> ($past(!st_pr) && $past(st_hv)));

  a_r7_aligned_addr: assert property (@(posedge clk) disable iff (!rst_n)
    trace_req |-> ($past(nia[PRIV_W-1:0]) == '0 &&
                   $past(nia[XLEN-1:PRIV_W]) == $past(bp_q[XLEN-1:PRIV_W])));

endmodule

// File: tb/test_ibrk_unit.sv
module test_ibrk_unit;

  typedef struct {
    int          due;
    logic        req;
    logic [63:0] sts;
    logic [63:0] rd;
    string       tag;
  } exp_t;

  localparam logic [63:0] STS = 64'h0000_0000_4010_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bp_we = 1'b0, rs_en = 1'b0, nia_valid = 1'b0, st_pr = 1'b0, st_hv = 1'b0;
  logic [63:0] bp_wdata = '0, rs_data = '0, nia = '0;
  logic [63:0] bp_rdata, trace_status;
  logic        trace_req;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  logic [63:0] m_reg = '0;
  exp_t sb[$];
  exp_t e;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ibrk_unit i_ibrk_unit (
    .clk(clk), .rst_n(rst_n), .bp_we(bp_we), .bp_wdata(bp_wdata),
    .rs_en(rs_en), .rs_data(rs_data), .bp_rdata(bp_rdata),
    .nia_valid(nia_valid), .nia(nia), .st_pr(st_pr), .st_hv(st_hv),
    .trace_req(trace_req), .trace_status(trace_status)
  );

  // Independent privilege table: rows are selector values.
  function automatic bit model_priv(logic [1:0] s, logic pr, logic hv);
    bit [3:0] row;
    row = {(!pr && hv), (!pr && !hv), pr, 1'b0};
    return row[s];
  endfunction

  // Monitor: compare outputs against queued expectations.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      e = sb.pop_front();
      n_chk++;
      if (trace_req !== e.req || trace_status !== e.sts || bp_rdata !== e.rd) begin
        n_fail++;
        $display("FAIL %s actual req=%0b sts=%h rd=%h expected req=%0b sts=%h rd=%h",
                 e.tag, trace_req, trace_status, bp_rdata, e.req, e.sts, e.rd);
      end
    end
  end

  // Driver: apply one cycle of stimulus and push the expected result.
  task automatic step(input logic we, input logic [63:0] wd, input logic re, input logic [63:0] rv,
                      input logic v, input logic [63:0] a, input logic pr, input logic hv,
                      input string tag);
    exp_t x;
    @(posedge clk); #2;
    bp_we = we; bp_wdata = wd; rs_en = re; rs_data = rv;
    nia_valid = v; nia = a; st_pr = pr; st_hv = hv;
    x.req = v && (m_reg[1:0] != 2'b00) && model_priv(m_reg[1:0], pr, hv) &&
            (a[63:2] == m_reg[63:2]) && (a[1:0] == 2'b00);
    x.sts = x.req ? STS : 64'h0;
    if (re)      m_reg = rv;
    else if (we) m_reg = wd;
    x.rd  = m_reg;
    x.due = cyc + 1;
    x.tag = tag;
    sb.push_back(x);
  endtask

  task automatic idle(input string tag);
    step(1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, tag);
  endtask

  task automatic do_reset();
    idle("R1_drain");
    idle("R1_drain");
    @(posedge clk); #2;
    rst_n = 1'b0; m_reg = '0;
    bp_we = 1'b0; rs_en = 1'b0; nia_valid = 1'b0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    sb.delete();
    @(negedge clk);
    n_chk++;
    if (bp_rdata !== '0 || trace_req !== 1'b0 || trace_status !== '0) begin
      n_fail++;
      $display("FAIL R1 actual rd=%h req=%0b sts=%h expected rd=0 req=0 sts=0",
               bp_rdata, trace_req, trace_status);
    end
  endtask

  initial begin
    do_reset();

    // R10: write and matching address in the same cycle use the old value.
    step(1, 64'h1001, 0, '0, 1, 64'h1000, 1, 0, "R10_same_cycle");
    step(0, '0, 0, '0, 1, 64'h1000, 1, 0, "R4_user_hit");
    step(0, '0, 0, '0, 1, 64'h1000, 1, 1, "R4_user_hv_hit");
    step(0, '0, 0, '0, 1, 64'h1000, 0, 0, "R4_user_miss");
    step(0, '0, 0, '0, 0, 64'h1000, 1, 0, "R8_not_valid");
    step(0, '0, 0, '0, 1, 64'h1004, 1, 0, "R7_addr_off");
    step(0, '0, 0, '0, 1, 64'h1002, 1, 0, "R7_low_bits");
    step(0, '0, 0, '0, 1, 64'h1000, 1, 0, "R9_status");
    idle("R8_pulse_end");

    step(1, 64'h2002, 0, '0, 0, '0, 0, 0, "R2_write");
    step(0, '0, 0, '0, 1, 64'h2000, 0, 0, "R5_sup_hit");
    step(0, '0, 0, '0, 1, 64'h2000, 0, 1, "R5_sup_hv_miss");
    step(0, '0, 0, '0, 1, 64'h2000, 1, 0, "R5_sup_pr_miss");

    step(1, 64'h3003, 0, '0, 0, '0, 0, 0, "R2_write");
    step(0, '0, 0, '0, 1, 64'h3000, 0, 1, "R6_hyp_hit");
    step(0, '0, 0, '0, 1, 64'h3000, 0, 0, "R6_hyp_miss");
    step(0, '0, 0, '0, 1, 64'h3000, 1, 1, "R6_hyp_pr_miss");
    step(0, '0, 0, '0, 1, 64'h2000, 0, 0, "R10_old_removed");

    step(1, 64'h4000, 0, '0, 0, '0, 0, 0, "R2_write");
    for (int k = 0; k < 4; k++)
      step(0, '0, 0, '0, 1, 64'h4000, k[0], k[1], "R3_disabled");

    step(1, 64'h6001, 1, 64'h5001, 0, '0, 0, 0, "R11_both_loads");
    step(0, '0, 0, '0, 1, 64'h5000, 1, 0, "R11_restore_hit");
    step(0, '0, 0, '0, 1, 64'h6000, 1, 0, "R11_write_lost");

    step(1, 64'hFFFF_FFFF_FFFF_FFFD, 0, '0, 0, '0, 0, 0, "R2_high");
    step(0, '0, 0, '0, 1, 64'hFFFF_FFFF_FFFF_FFFC, 1, 0, "R7_high_hit");
    step(0, '0, 0, '0, 1, 64'hFFFF_FFFF_FFFF_FFFC, 1, 0, "R8_back_to_back");

    step(1, 64'h7001, 0, '0, 0, '0, 0, 0, "R2_write");
    do_reset();
    step(0, '0, 0, '0, 1, 64'h7000, 1, 0, "R1_disarmed");
    idle("R1_idle");
    idle("R1_idle");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule